// File: doc/BRIEF.md
# Receiver lock indication and out-of-lock sample muting

This block sits between a digital audio receiver front end and the audio processing chain. It takes three status flags: a clock-recovery lock flag that arrives from another clock domain, a decoder lock flag, and a flag that says the incoming stream carries linear PCM audio. From these it produces two registered indicator outputs. The lock indicator can drive an external analog mute circuit. The PCM-detect indicator reports whether a valid PCM stream is present.

In the default mode the lock indicator is high only when the recovered clock and the decoder are both locked and the stream is PCM. A host configuration bit removes the PCM qualification, so that the indicator then reflects lock status alone.

The block also gates the sample stream. On every sample strobe during which the receiver is not locked, all channels are replaced by zero. This is an immediate hard mute with no ramp. It acts independently of any soft mute further down the chain. A second host bit bypasses this gating. Both host bits are driven by the owning register file, which resets them to 0.

Top module: `lock_mute_ctrl`

## Requirements
- R1: While rst_ni is low, and until the first strobe after reset, lock_o, pcmdet_o and smp_valid_o are 0 and smp_o is all zero.
- R2: When pcm_qual_off_i=0, lock_o equals clk_lock AND dec_lock AND pcm, where clk_lock is the synchronised clk_lock_i. lock_o is registered, one cycle after the synchronised inputs.
- R3: When both locks are present, pcm_i=0 and pcm_qual_off_i=0, lock_o is 0.
- R4: When pcm_qual_off_i=1, lock_o equals clk_lock AND dec_lock, and pcm_i has no effect on it.
- R5: pcmdet_o equals clk_lock AND dec_lock AND pcm, registered. pcm_qual_off_i and mute_bypass_i have no effect on it.
- R6: A strobe (smp_valid_i=1) is treated as unlocked when synchronised clk_lock AND dec_lock_i is 0 in that cycle. If the strobe is unlocked and mute_bypass_i=0, every channel of smp_o is 0 in the next cycle, on that same strobe, with no ramp.
- R7: A strobe taken while locked is passed to smp_o unchanged in the next cycle.
- R8: When mute_bypass_i=1, every strobe is passed unchanged, whatever the lock state.
- R9: clk_lock_i passes through a two-flop synchroniser. A change on it, set up before a rising edge, reaches lock_o after the third rising edge and not before.
- R10: smp_valid_o is a one-cycle copy of smp_valid_i, delayed by one cycle. smp_o holds its last value while no strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_lock_i | input | 1 | Clock-recovery lock flag, asynchronous |
| dec_lock_i | input | 1 | Decoder lock flag, synchronous |
| pcm_i | input | 1 | Stream carries PCM audio, synchronous |
| pcm_qual_off_i | input | 1 | Host bit: lock_o ignores PCM status |
| mute_bypass_i | input | 1 | Host bit: disable out-of-lock sample mute |
| smp_valid_i | input | 1 | Sample strobe |
| smp_i | input | NUM_CH*SMP_W | Channel samples, channel 0 in the low bits |
| lock_o | output | 1 | Lock indicator |
| pcmdet_o | output | 1 | PCM-detect indicator |
| smp_valid_o | output | 1 | Output sample strobe |
| smp_o | output | NUM_CH*SMP_W | Gated channel samples |

## Verification
The hardest case to reach from the ports is lock being lost on exactly the cycle of a sample strobe. The sample must already be zeroed on that strobe and not one strobe later. The bench drops the synchronous decoder lock on the same clock edge that carries a nonzero strobe, and expects zero on the next cycle. The synchroniser depth is measured separately: the bench drops clk_lock_i and samples lock_o after the second and after the third edge. All 32 combinations of the five flag and host-bit inputs are swept, and the indicators and the gated samples are checked for each one.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef struct packed {
    logic clk_lock;
    logic dec_lock;
    logic pcm;
  } lock_state_t;

  localparam int unsigned MIN_SYNC_STAGES = 2;
endpackage

// File: rtl/lmc_sync.sv
module lmc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q[s] <= 1'b0;
      end else begin
        if (s == 0) chain_q[s] <= d_i;
        else        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lmc_lock_comb.sv
module lmc_lock_comb
  import lmc_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  lock_state_t st_i,
  input  logic        pcm_qual_off_i,
  output logic        locked_o,
  output logic        lock_o,
  output logic        pcmdet_o
);
  logic lock_d, pcmdet_d;

  // locked_o feeds the sample gate without a register so the mute hits the same strobe
  assign locked_o = st_i.clk_lock & st_i.dec_lock;
  assign pcmdet_d = locked_o & st_i.pcm;
  assign lock_d   = pcm_qual_off_i ? locked_o : pcmdet_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_o   <= 1'b0;
      pcmdet_o <= 1'b0;
    end else begin
      lock_o   <= lock_d;
      pcmdet_o <= pcmdet_d;
    end
  end
endmodule

// File: rtl/lmc_smp_gate.sv
module lmc_smp_gate #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned SMP_W  = 24,
  localparam int unsigned BUS_W = NUM_CH * SMP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pass_i,
  input  logic             valid_i,
  input  logic [BUS_W-1:0] smp_i,
  output logic             valid_o,
  output logic [BUS_W-1:0] smp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SMP_W-1:0] ch_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ch_q <= '0;
      end else if (valid_i) begin
        ch_q <= pass_i ? smp_i[c*SMP_W +: SMP_W] : '0;
      end
    end
    assign smp_o[c*SMP_W +: SMP_W] = ch_q;
  end
endmodule

// File: rtl/lock_mute_ctrl.sv
module lock_mute_ctrl
  import lmc_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned SMP_W       = 24,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned BUS_W      = NUM_CH * SMP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_lock_i,
  input  logic             dec_lock_i,
  input  logic             pcm_i,
  input  logic             pcm_qual_off_i,
  input  logic             mute_bypass_i,
  input  logic             smp_valid_i,
  input  logic [BUS_W-1:0] smp_i,
  output logic             lock_o,
  output logic             pcmdet_o,
  output logic             smp_valid_o,
  output logic [BUS_W-1:0] smp_o
);
  localparam int unsigned STAGES_EFF =
    (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic        clk_lock_s;
  logic        locked;
  lock_state_t st;

  lmc_sync #(.STAGES(STAGES_EFF)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (clk_lock_i),
    .q_o   (clk_lock_s)
  );

  assign st = '{clk_lock: clk_lock_s, dec_lock: dec_lock_i, pcm: pcm_i};

  lmc_lock_comb u_comb (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .st_i          (st),
    .pcm_qual_off_i(pcm_qual_off_i),
    .locked_o      (locked),
    .lock_o        (lock_o),
    .pcmdet_o      (pcmdet_o)
  );

  lmc_smp_gate #(.NUM_CH(NUM_CH), .SMP_W(SMP_W)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pass_i (locked | mute_bypass_i),
    .valid_i(smp_valid_i),
    .smp_i  (smp_i),
    .valid_o(smp_valid_o),
    .smp_o  (smp_o)
  );
endmodule

// File: rtl/lock_mute_ctrl_chk.sv
module lock_mute_ctrl_chk #(
  parameter int unsigned BUS_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clk_lock_s,
  input logic             dec_lock_i,
  input logic             pcm_i,
  input logic             pcm_qual_off_i,
  input logic             mute_bypass_i,
  input logic             smp_valid_i,
  input logic [BUS_W-1:0] smp_i,
  input logic             lock_o,
  input logic             pcmdet_o,
  input logic             smp_valid_o,
  input logic [BUS_W-1:0] smp_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> (!lock_o && !pcmdet_o && !smp_valid_o)); // R1
  AST_LOCK_NEEDS_PCM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pcm_qual_off_i && !pcm_i) |=> !lock_o); // R3
  AST_LOCK_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pcm_qual_off_i && clk_lock_s && dec_lock_i && pcm_i) |=> lock_o); // R2
  AST_LOCK_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcm_qual_off_i |=> (lock_o == $past(clk_lock_s && dec_lock_i))); // R4
  AST_PCMDET_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcmdet_o |-> $past(pcm_i && dec_lock_i && clk_lock_s)); // R5
  AST_HARD_MUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && !mute_bypass_i && !(clk_lock_s && dec_lock_i)) |=> (smp_o == '0)); // R6
  AST_LOCKED_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && clk_lock_s && dec_lock_i) |=> (smp_o == $past(smp_i))); // R7
  AST_BYPASS_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_valid_i && mute_bypass_i) |=> (smp_o == $past(smp_i))); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> ($stable(smp_o) && !smp_valid_o)); // R10
endmodule

bind lock_mute_ctrl lock_mute_ctrl_chk #(.BUS_W(BUS_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .clk_lock_s    (clk_lock_s),
  .dec_lock_i    (dec_lock_i),
  .pcm_i         (pcm_i),
  .pcm_qual_off_i(pcm_qual_off_i),
  .mute_bypass_i (mute_bypass_i),
  .smp_valid_i   (smp_valid_i),
  .smp_i         (smp_i),
  .lock_o        (lock_o),
  .pcmdet_o      (pcmdet_o),
  .smp_valid_o   (smp_valid_o),
  .smp_o         (smp_o)
);

// File: tb/lock_mute_ctrl_tb.sv
module lock_mute_ctrl_tb;
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned SMP_W  = 24;
  localparam int unsigned BUS_W  = NUM_CH * SMP_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             clk_lock_i = 1'b0, dec_lock_i = 1'b0, pcm_i = 1'b0;
  logic             pcm_qual_off_i = 1'b0, mute_bypass_i = 1'b0;
  logic             smp_valid_i = 1'b0;
  logic [BUS_W-1:0] smp_i = '0;
  logic             lock_o, pcmdet_o, smp_valid_o;
  logic [BUS_W-1:0] smp_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  lock_mute_ctrl #(.NUM_CH(NUM_CH), .SMP_W(SMP_W), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_lock_i(clk_lock_i), .dec_lock_i(dec_lock_i),
    .pcm_i(pcm_i), .pcm_qual_off_i(pcm_qual_off_i), .mute_bypass_i(mute_bypass_i),
    .smp_valid_i(smp_valid_i), .smp_i(smp_i), .lock_o(lock_o), .pcmdet_o(pcmdet_o),
    .smp_valid_o(smp_valid_o), .smp_o(smp_o)
  );

  always @(posedge clk_i) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [BUS_W-1:0] act, input logic [BUS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nedge(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  function automatic logic [BUS_W-1:0] pattern(input int k);
    logic [SMP_W-1:0] a;
    a = 24'hA50000 ^ (24'(k) * 24'h011111) ^ 24'h00003C;
    return {~a, a};
  endfunction

  initial begin
    nedge(2);
    chk("R1 lock_o", BUS_W'(lock_o), '0);
    chk("R1 pcmdet_o", BUS_W'(pcmdet_o), '0);
    chk("R1 smp_valid_o", BUS_W'(smp_valid_o), '0);
    chk("R1 smp_o", smp_o, '0);
    rst_ni = 1'b1;
    nedge(2);
    chk("R1 post-reset smp_o", smp_o, '0);

    // full sweep of flags and host bits
    for (int k = 0; k < 32; k++) begin
      logic cl, dl, pc, ov, by, lk, exp_lock, exp_pcm;
      logic [BUS_W-1:0] d;
      {cl, dl, pc, ov, by} = 5'(k);
      clk_lock_i = cl; dec_lock_i = dl; pcm_i = pc;
      pcm_qual_off_i = ov; mute_bypass_i = by;
      nedge(4);
      lk = cl & dl;
      exp_pcm = lk & pc;
      exp_lock = ov ? lk : exp_pcm;
      if (ov) chk("R4 lock_o override", BUS_W'(lock_o), BUS_W'(exp_lock));
      else if (lk && !pc) chk("R3 lock_o non-PCM", BUS_W'(lock_o), BUS_W'(exp_lock));
      else chk("R2 lock_o default", BUS_W'(lock_o), BUS_W'(exp_lock));
      chk("R5 pcmdet_o", BUS_W'(pcmdet_o), BUS_W'(exp_pcm));
      d = pattern(k);
      smp_i = d; smp_valid_i = 1'b1;
      nedge(1);
      smp_valid_i = 1'b0;
      if (by) chk("R8 bypass pass", smp_o, d);
      else if (lk) chk("R7 locked pass", smp_o, d);
      else chk("R6 hard mute", smp_o, '0);
      chk("R10 valid pulse", BUS_W'(smp_valid_o), BUS_W'(1));
      smp_i = ~d;
      nedge(1);
      chk("R10 valid low", BUS_W'(smp_valid_o), '0);
      chk("R10 hold", smp_o, (by || lk) ? d : '0);
    end

    // lock lost on the very strobe
    clk_lock_i = 1; dec_lock_i = 1; pcm_i = 1; pcm_qual_off_i = 0; mute_bypass_i = 0;
    nedge(4);
    smp_i = pattern(40); smp_valid_i = 1'b1;
    nedge(1);
    chk("R7 pre-loss pass", smp_o, pattern(40));
    smp_i = pattern(41); dec_lock_i = 1'b0;
    nedge(1);
    smp_valid_i = 1'b0;
    chk("R6 same-strobe mute", smp_o, '0);
    dec_lock_i = 1'b1;
    nedge(2);

    // synchroniser depth
    pcm_qual_off_i = 1'b1;
    nedge(4);
    chk("R9 start high", BUS_W'(lock_o), BUS_W'(1));
    clk_lock_i = 1'b0;
    nedge(2);
    chk("R9 after two edges", BUS_W'(lock_o), BUS_W'(1));
    nedge(1);
    chk("R9 after three edges", BUS_W'(lock_o), '0);
    clk_lock_i = 1'b1;
    nedge(2);
    chk("R9 rise after two edges", BUS_W'(lock_o), '0);
    nedge(1);
    chk("R9 rise after three edges", BUS_W'(lock_o), BUS_W'(1));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule